// File: doc/BRIEF.md
# Fixed-Priority Command Queue Arbiter

This block sits between six command queues and one downstream command consumer. A queue only competes for the consumer once a trigger has armed it. The trigger can come from software or from an already filtered hardware event. In every cycle where the consumer is ready, the arbiter grants the armed, non-empty queue with the lowest index. It forwards that queue's head command together with the queue number, and pops the queue in the same cycle the handshake completes.

Each command word carries two control bits:

- The top bit (bit CW-1) marks the last command of the queue's current run. Issuing such a command disarms the queue.
- The bit below it (bit CW-2) says that the next command belongs to the same group.

If a different queue is granted while a group is still open, the arbiter records a sticky coherency error against the queue that owned the group. The per-queue coherency errors, each gated by its enable bit, are combined into one interrupt line. A trigger that reaches a queue that is already armed is an overrun and sets a sticky overrun flag.

Queue storage, trigger filtering and the far side of the downstream link are outside this block.

Top module: `cmdq_prio_arb`

## Requirements
- R1: While reset is held, and in the first cycle after it, all queues are disarmed, out_valid is 0, q_pop is all zero, all coherency and overrun flags are 0, and irq is 0.
- R2: A queue whose armed bit is 0, or whose q_nempty bit is 0, is never popped and never drives the output, even when it holds commands.
- R3: A pulse on q_sw_trig[i] or on q_hw_trig[i] while queue i is disarmed sets armed[i] from the next cycle onward.
- R4: When queue i issues a command with bit CW-1 (end of run) set, armed[i] is 0 from the next cycle. Commands left in the queue then wait for a new trigger.
- R5: Among armed, non-empty queues, the lowest index is granted. out_qid carries that index and out_cmd carries that queue's head command.
- R6: q_pop is one-hot or zero. It is set only in a cycle where out_valid and out_ready are both 1, on the granted queue. With out_ready low, no queue is popped.
- R7: Consecutive grants to the same queue while bit CW-2 (group continues) of its previous command was set raise no coherency error.
- R8: If a grant goes to queue j while the last issued command came from queue k ≠ j, and that command had bit CW-2 set and bit CW-1 clear, then coh_err[k] is set from the next cycle.
- R9: coh_err bits stay set until a 1 is written to the matching coh_clr bit. A new error in the same cycle as the clear wins.
- R10: irq is 1 exactly when some queue has both coh_err and irq_en set.
- R11: A trigger to a queue that is already armed sets its ovr_err bit and leaves it armed. ovr_err stays set until the matching ovr_clr bit is pulsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_sw_trig | input | NQ | Software trigger pulse per queue |
| q_hw_trig | input | NQ | Filtered hardware trigger pulse per queue |
| q_nempty | input | NQ | Queue holds at least one command |
| q_cmd | input | NQ*CW | Head command of each queue, queue i at bits [i*CW +: CW] |
| q_pop | output | NQ | Pop strobe, one per queue |
| out_valid | output | 1 | A command is offered downstream |
| out_ready | input | 1 | Consumer accepts in this cycle |
| out_cmd | output | CW | Offered command |
| out_qid | output | QW | Index of the queue that owns out_cmd |
| armed | output | NQ | Arm state per queue |
| coh_clr | input | NQ | Write-1-to-clear for coh_err |
| ovr_clr | input | NQ | Write-1-to-clear for ovr_err |
| irq_en | input | NQ | Interrupt enable per queue |
| coh_err | output | NQ | Sticky coherency error per queue |
| ovr_err | output | NQ | Sticky trigger overrun per queue |
| irq | output | 1 | Combined coherency interrupt |

## Verification
The bench loads commands into queues that have not been triggered and confirms nothing leaves. A design that ignored the arm state would leak these commands at once. It triggers three queues together while the consumer is stalled, then releases the consumer and expects the order 1, 3, 5. Reversed or round-robin priority, or a pop during the stall, breaks that order.

To cover coherency, the bench issues exactly one command of an open group, lets queue 0 cut in, and expects the flag on the interrupted queue only. It also checks that a group running within a single queue leaves the flag clear. A design that flagged the wrong queue, or flagged every change of queue, shows up here.

Overrun and re-arming are exercised on queues that stay armed while empty, and on a leftover command that must wait for a second trigger.

// File: rtl/cqa_pkg.sv
package cqa_pkg;

  // widest queue vector the helpers accept
  localparam int VEC_W = 32;

  // isolate the least significant set bit (highest priority request)
  function automatic logic [VEC_W-1:0] lowest_set(input logic [VEC_W-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  // binary position of a one-hot vector
  function automatic logic [4:0] onehot_index(input logic [VEC_W-1:0] oh);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < VEC_W; i++) begin
      if (oh[i]) r = 5'(i);
    end
    return r;
  endfunction

  // a group stays open after a command that continues and does not end the run
  function automatic logic group_stays_open(input logic more, input logic last);
    return more & ~last;
  endfunction

endpackage

// File: rtl/cqa_arm.sv
module cqa_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic disarm,
  input  logic ovr_clr,
  output logic armed,
  output logic ovr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      // a trigger only arms an idle queue; on an armed queue it is an overrun
      armed <= armed ? ~disarm : trig;
      ovr   <= (ovr & ~ovr_clr) | (armed & trig);
    end
  end

endmodule

// File: rtl/cqa_pick.sv
module cqa_pick
  import cqa_pkg::*;
#(
  parameter int NQ = 6,
  parameter int CW = 16,
  parameter int QW = 3
) (
  input  logic [NQ-1:0]    elig,
  input  logic [NQ*CW-1:0] cmd_flat,
  output logic [NQ-1:0]    win_oh,
  output logic [QW-1:0]    win_idx,
  output logic [CW-1:0]    win_cmd,
  output logic             any
);

  logic [VEC_W-1:0] oh_wide;

  always_comb begin
    oh_wide = lowest_set(VEC_W'(elig));
    win_oh  = oh_wide[NQ-1:0];
    win_idx = QW'(onehot_index(oh_wide));
    any     = |elig;
    win_cmd = '0;
    for (int i = 0; i < NQ; i++) begin
      if (win_oh[i]) win_cmd = win_cmd | cmd_flat[i*CW +: CW];
    end
  end

endmodule

// File: rtl/cqa_coh.sv
module cqa_coh
  import cqa_pkg::*;
#(
  parameter int NQ = 6,
  parameter int QW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [QW-1:0] win_idx,
  input  logic          cmd_more,
  input  logic          cmd_last,
  input  logic [NQ-1:0] coh_clr,
  output logic [NQ-1:0] coh_err,
  output logic          grp_open,
  output logic [QW-1:0] grp_owner,
  output logic          split_hit
);

  logic [NQ-1:0] set_v;

  always_comb begin
    split_hit = fire & grp_open & (win_idx != grp_owner);
    set_v     = split_hit ? (NQ'(1) << grp_owner) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_open  <= 1'b0;
      grp_owner <= '0;
      coh_err   <= '0;
    end else begin
      if (fire) begin
        grp_open  <= group_stays_open(cmd_more, cmd_last);
        grp_owner <= win_idx;
      end
      coh_err <= (coh_err & ~coh_clr) | set_v;
    end
  end

endmodule

// File: rtl/cmdq_prio_arb.sv
module cmdq_prio_arb #(
  parameter  int NQ = 6,
  parameter  int CW = 16,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NQ-1:0]    q_sw_trig,
  input  logic [NQ-1:0]    q_hw_trig,
  input  logic [NQ-1:0]    q_nempty,
  input  logic [NQ*CW-1:0] q_cmd,
  output logic [NQ-1:0]    q_pop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CW-1:0]    out_cmd,
  output logic [QW-1:0]    out_qid,
  output logic [NQ-1:0]    armed,
  input  logic [NQ-1:0]    coh_clr,
  input  logic [NQ-1:0]    ovr_clr,
  input  logic [NQ-1:0]    irq_en,
  output logic [NQ-1:0]    coh_err,
  output logic [NQ-1:0]    ovr_err,
  output logic             irq
);

  localparam int LAST_BIT = CW - 1;
  localparam int MORE_BIT = CW - 2;

  // named internal events, also observed by the bound checker
  logic [NQ-1:0] trig_any;
  logic [NQ-1:0] elig;
  logic [NQ-1:0] win_oh;
  logic [NQ-1:0] disarm;
  logic          fire;
  logic          grp_open;
  logic [QW-1:0] grp_owner;
  logic          split_hit;

  assign trig_any = q_sw_trig | q_hw_trig;
  assign elig     = armed & q_nempty;

  for (genvar g = 0; g < NQ; g++) begin : g_arm
    cqa_arm u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (trig_any[g]),
      .disarm  (disarm[g]),
      .ovr_clr (ovr_clr[g]),
      .armed   (armed[g]),
      .ovr     (ovr_err[g])
    );
  end

  cqa_pick #(.NQ(NQ), .CW(CW), .QW(QW)) u_pick (
    .elig     (elig),
    .cmd_flat (q_cmd),
    .win_oh   (win_oh),
    .win_idx  (out_qid),
    .win_cmd  (out_cmd),
    .any      (out_valid)
  );

  assign fire   = out_valid & out_ready;
  assign q_pop  = fire ? win_oh : '0;
  assign disarm = out_cmd[LAST_BIT] ? q_pop : '0;

  cqa_coh #(.NQ(NQ), .QW(QW)) u_coh (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .win_idx   (out_qid),
    .cmd_more  (out_cmd[MORE_BIT]),
    .cmd_last  (out_cmd[LAST_BIT]),
    .coh_clr   (coh_clr),
    .coh_err   (coh_err),
    .grp_open  (grp_open),
    .grp_owner (grp_owner),
    .split_hit (split_hit)
  );

  assign irq = |(coh_err & irq_en);

endmodule

// File: rtl/cmdq_prio_arb_chk.sv
module cmdq_prio_arb_chk #(
  parameter int NQ = 6,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NQ-1:0] q_pop,
  input logic [NQ-1:0] elig,
  input logic [NQ-1:0] armed,
  input logic [NQ-1:0] trig_any,
  input logic          out_valid,
  input logic          out_ready,
  input logic [CW-1:0] out_cmd,
  input logic [NQ-1:0] coh_err,
  input logic [NQ-1:0] coh_clr,
  input logic [NQ-1:0] ovr_err,
  input logic          irq
);

  localparam logic [NQ-1:0] ONE = NQ'(1);

  assert_pop_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_pop));

  assert_pop_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_pop) |-> (out_valid && out_ready));

  assert_pop_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop & ~elig) == '0);

  assert_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_pop) |-> (((q_pop - ONE) & elig) == '0));

  assert_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|q_pop) && out_cmd[CW-1]) |=> (($past(q_pop) & armed) == '0));

  assert_coh_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(coh_err) & ~coh_err) & ~$past(coh_clr)) == '0));

  assert_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(armed) & $past(trig_any)) & ~ovr_err) == '0));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|coh_err));

endmodule

bind cmdq_prio_arb cmdq_prio_arb_chk #(.NQ(NQ), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .q_pop     (q_pop),
  .elig      (elig),
  .armed     (armed),
  .trig_any  (trig_any),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_cmd   (out_cmd),
  .coh_err   (coh_err),
  .coh_clr   (coh_clr),
  .ovr_err   (ovr_err),
  .irq       (irq)
);

// File: tb/sim_cmdq_prio_arb.sv
`timescale 1ns/100ps
module sim_cmdq_prio_arb;
  localparam int NQ = 6;
  localparam int CW = 16;
  localparam int QW = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NQ-1:0]    q_sw_trig = '0;
  logic [NQ-1:0]    q_hw_trig = '0;
  logic [NQ-1:0]    q_nempty;
  logic [NQ*CW-1:0] q_cmd;
  logic [NQ-1:0]    q_pop;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [CW-1:0]    out_cmd;
  logic [QW-1:0]    out_qid;
  logic [NQ-1:0]    armed;
  logic [NQ-1:0]    coh_clr = '0;
  logic [NQ-1:0]    ovr_clr = '0;
  logic [NQ-1:0]    irq_en = '0;
  logic [NQ-1:0]    coh_err;
  logic [NQ-1:0]    ovr_err;
  logic             irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmdq_prio_arb #(.NQ(NQ), .CW(CW)) u0 (.*);

  // queue storage model: 8 entries per queue
  logic [CW-1:0] mem [NQ][8];
  logic [2:0]    head [NQ];
  logic [2:0]    tail [NQ];

  initial begin
    for (int q = 0; q < NQ; q++) begin
      head[q] = '0;
      tail[q] = '0;
    end
  end

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      q_nempty[q]          = (head[q] != tail[q]);
      q_cmd[q*CW +: CW]    = mem[q][head[q]];
    end
  end

  always @(posedge clk) begin
    for (int q = 0; q < NQ; q++) begin
      if (q_pop[q]) head[q] <= head[q] + 3'd1;
    end
  end

  // scoreboard of expected issues, in order
  logic [QW+CW-1:0] exp_q [$];

  function automatic logic [CW-1:0] mk(input bit last, input bit more, input int pay);
    return {last, more, 14'(pay)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  // load a command into a queue; the expected-order list is pushed separately
  task automatic load(input int q, input logic [CW-1:0] c);
    mem[q][tail[q]] = c;
    tail[q] = tail[q] + 3'd1;
  endtask

  task automatic expect_issue(input int q, input logic [CW-1:0] c);
    exp_q.push_back({QW'(q), c});
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    for (int i = 0; i < 50; i++) begin
      if (exp_q.size() == 0) break;
      step();
    end
    step();
    chk(exp_q.size() == 0, "R5 scoreboard drained", 32'(exp_q.size()), 32'd0);
  endtask

  // monitor: compares each completed handshake against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected issue", {13'd0, out_qid, out_cmd}, 32'd0);
      end else begin
        logic [QW+CW-1:0] e;
        e = exp_q.pop_front();
        chk({out_qid, out_cmd} == e, "R5 issue order/content",
            {13'd0, out_qid, out_cmd}, {13'd0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL all watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1: reset state
    chk(armed == '0 && !out_valid && q_pop == '0, "R1 reset arm/valid", {armed, out_valid}, 0);
    chk(coh_err == '0 && ovr_err == '0 && !irq, "R1 reset flags", {coh_err, ovr_err, irq}, 0);
    rst_n = 1'b1;
    step();
    chk(armed == '0 && !out_valid && coh_err == '0 && ovr_err == '0, "R1 after reset", {armed, coh_err}, 0);

    // R2: commands in an untriggered queue stay put
    out_ready = 1'b1;
    load(2, mk(0, 1, 'h21));
    load(2, mk(1, 0, 'h22));
    load(2, mk(1, 0, 'h23));
    step(4);
    chk(!out_valid && q_pop == '0, "R2 unarmed queue silent", {out_valid, q_pop}, 0);

    // R3/R4/R7: software trigger, group in one queue, disarm at end of run
    expect_issue(2, mk(0, 1, 'h21));
    expect_issue(2, mk(1, 0, 'h22));
    q_sw_trig[2] = 1'b1;
    step();
    q_sw_trig[2] = 1'b0;
    chk(armed[2], "R3 sw trigger arms", 32'(armed), 32'h4);
    drain();
    chk(armed[2] == 1'b0, "R4 end of run disarms", 32'(armed), 32'h0);
    chk(!out_valid, "R4 leftover waits for trigger", 32'(out_valid), 0);
    chk(coh_err == '0, "R7 same-queue group no error", 32'(coh_err), 0);

    // R5/R6: priority with stalled consumer
    out_ready = 1'b0;
    load(5, mk(1, 0, 'h51));
    load(1, mk(1, 0, 'h11));
    load(3, mk(1, 0, 'h31));
    q_hw_trig = 6'b101010;
    step();
    q_hw_trig = '0;
    chk(armed == 6'b101010, "R3 hw trigger arms", 32'(armed), 32'h2a);
    step();
    chk(out_valid && q_pop == '0, "R6 no pop while stalled", {out_valid, q_pop}, 32'h40);
    chk(out_qid == 3'd1, "R5 lowest index offered", 32'(out_qid), 1);
    expect_issue(1, mk(1, 0, 'h11));
    expect_issue(3, mk(1, 0, 'h31));
    expect_issue(5, mk(1, 0, 'h51));
    out_ready = 1'b1;
    drain();

    // R8/R9/R10: group split by a higher-priority queue
    out_ready = 1'b0;
    load(4, mk(0, 1, 'h41));
    load(4, mk(1, 0, 'h42));
    q_sw_trig[4] = 1'b1;
    step();
    q_sw_trig[4] = 1'b0;
    expect_issue(4, mk(0, 1, 'h41));
    out_ready = 1'b1;
    step();
    out_ready = 1'b0;
    load(0, mk(1, 0, 'h01));
    q_hw_trig[0] = 1'b1;
    step();
    q_hw_trig[0] = 1'b0;
    chk(coh_err == '0, "R8 no error before split", 32'(coh_err), 0);
    expect_issue(0, mk(1, 0, 'h01));
    expect_issue(4, mk(1, 0, 'h42));
    out_ready = 1'b1;
    drain();
    chk(coh_err == 6'b010000, "R8 split flags owner", 32'(coh_err), 32'h10);
    chk(!irq, "R10 masked irq low", 32'(irq), 0);
    irq_en = 6'b010000;
    step();
    chk(irq, "R10 enabled irq high", 32'(irq), 1);
    step(3);
    chk(coh_err == 6'b010000, "R9 flag sticky", 32'(coh_err), 32'h10);
    coh_clr = 6'b000001;
    step();
    coh_clr = '0;
    chk(coh_err == 6'b010000, "R9 clear of other bit ignored", 32'(coh_err), 32'h10);
    coh_clr = 6'b010000;
    step();
    coh_clr = '0;
    chk(coh_err == '0 && !irq, "R9 write-1 clears", {coh_err, irq}, 0);

    // R11: overrun on an armed queue
    q_sw_trig[3] = 1'b1;
    step();
    q_sw_trig[3] = 1'b0;
    chk(armed[3] && !ovr_err[3], "R11 first trigger arms only", {armed, ovr_err}, 32'h200);
    q_hw_trig[3] = 1'b1;
    step();
    q_hw_trig[3] = 1'b0;
    chk(ovr_err == 6'b001000 && armed[3], "R11 overrun flagged", {armed, ovr_err}, 32'h208);
    step(2);
    chk(ovr_err == 6'b001000, "R11 overrun sticky", 32'(ovr_err), 32'h8);
    ovr_clr[3] = 1'b1;
    step();
    ovr_clr[3] = 1'b0;
    chk(ovr_err == '0, "R11 overrun cleared", 32'(ovr_err), 0);
    expect_issue(3, mk(1, 0, 'h32));
    load(3, mk(1, 0, 'h32));
    drain();
    chk(armed[3] == 1'b0, "R4 armed empty queue issues on load", 32'(armed), 0);

    // R3: leftover in queue 2 needs a fresh trigger
    expect_issue(2, mk(1, 0, 'h23));
    q_sw_trig[2] = 1'b1;
    step();
    q_sw_trig[2] = 1'b0;
    drain();
    chk(armed == '0 && coh_err == '0, "R3 rearm issues leftover", {armed, coh_err}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule